// File: doc/BRIEF.md
# Two-Pulse Tamper-Evident Read Controller

This controller sequences accesses to a resistive crossbar memory whose cells drift a little every time they are sensed. Analog drivers and sense amplifiers sit outside the block. The controller tells them which kind of pulse to apply, at which amplitude code and on which row and column. It receives back a comparator bit and a digitised resistance code. A stored 1 is the low-resistance state and a stored 0 is the high-resistance state. A write drives the SET level for a 1 or the RESET level for a 0 on the selected row, with the selected column held at 0 V by the driver.

Every read or verify is made of two back-to-back pulses. The first pulse uses an amplitude and a length fixed at build time. The data bit is taken from the comparator on the last cycle of that first pulse. The second pulse uses an amplitude and a length taken from a write-once private key register, and the key is never presented anywhere except on the drive bus during that pulse. Someone who reads a cell without knowing the key leaves drift that cannot be cancelled exactly.

A verify command compares the sensed resistance code with an expected code. When the two differ by more than a tolerance given with the command, a tamper flag is set and stays set until reset.

Top module: `tamper_evident_read_ctrl`

## Requirements
- R1: After reset, drv_kind_o is 0 (idle), drv_amp_o is 0, and busy_o, done_o, rdata_o and tamper_o are all 0.
- R2: A read (op 0) or a verify (op 2) that is accepted drives kind 1 with amplitude PUB_AMP for PUB_DUR cycles, starting in the cycle after acceptance. It then drives kind 2 with the stored key amplitude for key duration code plus one cycles.
- R3: rdata_o takes the value of sense_hi_i from the last cycle of the first pulse, where 1 means the column current exceeded the reference (low-resistance state, logic 1). It holds that value until the next read or verify samples again. Writes leave it unchanged.
- R4: A write (op 1) drives kind 3 (SET) with amplitude SET_AMP when cmd_wbit_i is 1, or kind 4 (RESET) with amplitude RESET_AMP when it is 0. It does so for WR_DUR cycles, starting in the cycle after acceptance, and it needs no key.
- R5: done_o is high for exactly one cycle, directly after the last pulse cycle. busy_o is high from the first pulse cycle through the done cycle, and low otherwise.
- R6: The first key write stores the amplitude and duration codes and locks them. Every later key write has no effect on the second pulse.
- R7: A read or verify issued before any key is stored is ignored, and so is op 3. In both cases no pulse and no done follow.
- R8: A command presented while busy_o or done_o is high is ignored.
- R9: After a verify, tamper_o is set in the cycle after done when the absolute difference between the sensed code and cmd_expect_i exceeds cmd_tol_i. A difference equal to the tolerance does not set it.
- R10: Once set, tamper_o stays high until reset, whatever commands follow.
- R11: drv_row_o and drv_col_o show the accepted command's row and column for every cycle of the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_we_i | input | 1 | Private key write strobe |
| key_amp_i | input | AW | Second-pulse amplitude code |
| key_dur_i | input | DW | Second-pulse duration code (cycles minus one) |
| cmd_valid_i | input | 1 | Command strobe, taken only when idle |
| cmd_op_i | input | 2 | 0 read, 1 write, 2 verify, 3 none |
| cmd_row_i | input | ROW_W | Target row |
| cmd_col_i | input | COL_W | Target column |
| cmd_wbit_i | input | 1 | Write data |
| cmd_expect_i | input | RW | Expected resistance code for verify |
| cmd_tol_i | input | RW | Allowed code difference for verify |
| sense_hi_i | input | 1 | Column current above reference |
| sense_code_i | input | RW | Digitised cell resistance |
| drv_kind_o | output | 3 | 0 idle, 1 public pulse, 2 secret pulse, 3 SET, 4 RESET |
| drv_amp_o | output | AW | Amplitude code of the current pulse |
| drv_row_o | output | ROW_W | Driven row |
| drv_col_o | output | COL_W | Driven column |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion strobe |
| rdata_o | output | 1 | Last sensed data bit |
| tamper_o | output | 1 | Sticky tamper flag |

## Verification
Several properties are checked on every cycle. The secret pulse must follow the end of the public pulse, the pulse timer must count down one step per cycle, and the key must stay frozen once locked. The tamper flag must never clear and may only rise after a verify check. The target must stay fixed during an operation, and done must last a single cycle. Other behaviours only show up in the bench scenarios: the data bit is taken from the last public-pulse cycle and not from the decoy sense values around it, the second pulse uses the first key and not a later one, commands are dropped before a key exists or while busy, and the tolerance compare is tested on both sides of the expected code, including exactly at the tolerance.

// File: rtl/tpr_pkg.sv
package tpr_pkg;
  typedef enum logic [2:0] {
    DRV_IDLE  = 3'd0,
    DRV_PUB   = 3'd1,
    DRV_SEC   = 3'd2,
    DRV_SET   = 3'd3,
    DRV_RESET = 3'd4
  } drv_e;

  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_WRITE  = 2'd1,
    OP_VERIFY = 2'd2,
    OP_NONE   = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUB,
    ST_SEC,
    ST_WR,
    ST_DONE
  } st_e;
endpackage

// File: rtl/tpr_key_vault.sv
module tpr_key_vault #(
  parameter int AW = 6,
  parameter int DW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] amp_i,
  input  logic [DW-1:0] dur_i,
  output logic          locked_o,
  output logic [AW-1:0] amp_o,
  output logic [DW-1:0] dur_o
);
  logic          locked_q;
  logic [AW-1:0] amp_q;
  logic [DW-1:0] dur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      amp_q    <= '0;
      dur_q    <= '0;
    end else if (we_i && !locked_q) begin
      locked_q <= 1'b1;
      amp_q    <= amp_i;
      dur_q    <= dur_i;
    end
  end

  assign locked_o = locked_q;
  assign amp_o    = amp_q;
  assign dur_o    = dur_q;

  p_key_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |=> (locked_q && $stable(amp_q) && $stable(dur_q)));
endmodule

// File: rtl/tpr_pulse_timer.sv
module tpr_pulse_timer #(
  parameter int CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          expired_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  p_count_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/tpr_tamper_judge.sv
module tpr_tamper_judge #(
  parameter int RW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          check_i,
  input  logic [RW-1:0] code_i,
  input  logic [RW-1:0] expect_i,
  input  logic [RW-1:0] tol_i,
  output logic          tamper_o
);
  logic [RW-1:0] diff;
  logic          tamper_q;

  always_comb begin
    if (code_i >= expect_i) diff = code_i - expect_i;
    else                    diff = expect_i - code_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        tamper_q <= 1'b0;
    else if (check_i && (diff > tol_i)) tamper_q <= 1'b1;
  end

  assign tamper_o = tamper_q;

  p_tamper_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tamper_q |=> tamper_q);
  p_tamper_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tamper_q) |-> $past(check_i));
endmodule

// File: rtl/tamper_evident_read_ctrl.sv
module tamper_evident_read_ctrl
  import tpr_pkg::*;
#(
  parameter int ROW_W     = 4,
  parameter int COL_W     = 4,
  parameter int AW        = 6,
  parameter int DW        = 4,
  parameter int RW        = 8,
  parameter int PUB_AMP   = 12,
  parameter int PUB_DUR   = 3,
  parameter int WR_DUR    = 4,
  parameter int SET_AMP   = 40,
  parameter int RESET_AMP = 33
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             key_we_i,
  input  logic [AW-1:0]    key_amp_i,
  input  logic [DW-1:0]    key_dur_i,
  input  logic             cmd_valid_i,
  input  logic [1:0]       cmd_op_i,
  input  logic [ROW_W-1:0] cmd_row_i,
  input  logic [COL_W-1:0] cmd_col_i,
  input  logic             cmd_wbit_i,
  input  logic [RW-1:0]    cmd_expect_i,
  input  logic [RW-1:0]    cmd_tol_i,
  input  logic             sense_hi_i,
  input  logic [RW-1:0]    sense_code_i,
  output logic [2:0]       drv_kind_o,
  output logic [AW-1:0]    drv_amp_o,
  output logic [ROW_W-1:0] drv_row_o,
  output logic [COL_W-1:0] drv_col_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             rdata_o,
  output logic             tamper_o
);
  localparam int PW = $clog2(PUB_DUR + 1);
  localparam int WW = $clog2(WR_DUR + 1);
  localparam int MW = (PW > WW) ? PW : WW;
  localparam int CW = ((MW > DW) ? MW : DW) + 1;

  st_e              state_q;
  op_e              op_q, cmd_op;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             wbit_q;
  logic [RW-1:0]    expect_q, tol_q, code_q;
  logic             rdata_q;

  logic             key_locked;
  logic [AW-1:0]    key_amp;
  logic [DW-1:0]    key_dur;
  logic             accept, t_load, t_expired;
  logic [CW-1:0]    t_val;

  assign cmd_op = op_e'(cmd_op_i);

  tpr_key_vault #(.AW(AW), .DW(DW)) u_vault (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (key_we_i),
    .amp_i    (key_amp_i),
    .dur_i    (key_dur_i),
    .locked_o (key_locked),
    .amp_o    (key_amp),
    .dur_o    (key_dur)
  );

  always_comb begin
    accept = 1'b0;
    if (state_q == ST_IDLE && cmd_valid_i) begin
      unique case (cmd_op)
        OP_WRITE:            accept = 1'b1;
        OP_READ, OP_VERIFY:  accept = key_locked;
        default:             accept = 1'b0;
      endcase
    end
  end

  // timer reload: at accept for the first phase, at end of public pulse for secret pulse
  always_comb begin
    t_load = 1'b0;
    t_val  = '0;
    if (accept) begin
      t_load = 1'b1;
      t_val  = (cmd_op == OP_WRITE) ? CW'(WR_DUR - 1) : CW'(PUB_DUR - 1);
    end else if (state_q == ST_PUB && t_expired) begin
      t_load = 1'b1;
      t_val  = {{(CW-DW){1'b0}}, key_dur};
    end
  end

  tpr_pulse_timer #(.CW(CW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (t_load),
    .load_val_i (t_val),
    .expired_o  (t_expired)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      op_q     <= OP_NONE;
      row_q    <= '0;
      col_q    <= '0;
      wbit_q   <= 1'b0;
      expect_q <= '0;
      tol_q    <= '0;
      code_q   <= '0;
      rdata_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          op_q     <= cmd_op;
          row_q    <= cmd_row_i;
          col_q    <= cmd_col_i;
          wbit_q   <= cmd_wbit_i;
          expect_q <= cmd_expect_i;
          tol_q    <= cmd_tol_i;
          state_q  <= (cmd_op == OP_WRITE) ? ST_WR : ST_PUB;
        end
        ST_PUB: if (t_expired) begin
          rdata_q <= sense_hi_i;   // sampled before the secret pulse starts
          code_q  <= sense_code_i;
          state_q <= ST_SEC;
        end
        ST_SEC:  if (t_expired) state_q <= ST_DONE;
        ST_WR:   if (t_expired) state_q <= ST_DONE;
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  tpr_tamper_judge #(.RW(RW)) u_judge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .check_i  (state_q == ST_DONE && op_q == OP_VERIFY),
    .code_i   (code_q),
    .expect_i (expect_q),
    .tol_i    (tol_q),
    .tamper_o (tamper_o)
  );

  always_comb begin
    drv_kind_o = DRV_IDLE;
    drv_amp_o  = '0;
    unique case (state_q)
      ST_PUB: begin
        drv_kind_o = DRV_PUB;
        drv_amp_o  = AW'(PUB_AMP);
      end
      ST_SEC: begin
        drv_kind_o = DRV_SEC;
        drv_amp_o  = key_amp;
      end
      ST_WR: begin
        drv_kind_o = wbit_q ? DRV_SET : DRV_RESET;
        drv_amp_o  = wbit_q ? AW'(SET_AMP) : AW'(RESET_AMP);
      end
      default: ;
    endcase
  end

  assign drv_row_o = row_q;
  assign drv_col_o = col_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_DONE);
  assign rdata_o   = rdata_q;

  p_sec_follows_pub_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PUB && t_expired) |=> (state_q == ST_SEC));
  p_done_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));
  p_read_needs_key_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PUB) |-> key_locked);
  p_busy_holds_op_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> (state_q == ST_IDLE || $stable(op_q)));
  p_target_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> (state_q == ST_IDLE || ($stable(row_q) && $stable(col_q))));
endmodule

// File: tb/tamper_evident_read_ctrl_test.sv
module tamper_evident_read_ctrl_test;
  localparam int PUB_AMP_T   = 12;
  localparam int PUB_DUR_T   = 3;
  localparam int WR_DUR_T    = 4;
  localparam int SET_AMP_T   = 40;
  localparam int RESET_AMP_T = 33;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       key_we = 1'b0;
  logic [5:0] key_amp = '0;
  logic [3:0] key_dur = '0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [3:0] cmd_row = '0, cmd_col = '0;
  logic       cmd_wbit = 1'b0;
  logic [7:0] cmd_expect = '0, cmd_tol = '0;
  logic       sense_hi = 1'b0;
  logic [7:0] sense_code = '0;
  logic [2:0] drv_kind;
  logic [5:0] drv_amp;
  logic [3:0] drv_row, drv_col;
  logic       busy, done, rdata, tamper;

  always #10 clk = ~clk;

  tamper_evident_read_ctrl #(
    .ROW_W(4), .COL_W(4), .AW(6), .DW(4), .RW(8),
    .PUB_AMP(PUB_AMP_T), .PUB_DUR(PUB_DUR_T), .WR_DUR(WR_DUR_T),
    .SET_AMP(SET_AMP_T), .RESET_AMP(RESET_AMP_T)
  ) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .key_we_i(key_we), .key_amp_i(key_amp), .key_dur_i(key_dur),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_row_i(cmd_row), .cmd_col_i(cmd_col),
    .cmd_wbit_i(cmd_wbit), .cmd_expect_i(cmd_expect), .cmd_tol_i(cmd_tol),
    .sense_hi_i(sense_hi), .sense_code_i(sense_code),
    .drv_kind_o(drv_kind), .drv_amp_o(drv_amp), .drv_row_o(drv_row), .drv_col_o(drv_col),
    .busy_o(busy), .done_o(done), .rdata_o(rdata), .tamper_o(tamper)
  );

  typedef struct {
    int    kind;
    int    amp;
    bit    done;
    int    row;
    int    col;
    int    rd;
    int    tm;
    string tag;
  } exp_t;

  exp_t  q[$];
  int    errors = 0;
  int    checks = 0;
  bit    locked_m = 1'b0;
  int    key_amp_m = 0;
  int    key_dur_m = 0;
  int    exp_rdata = 0;
  bit    exp_tamper = 1'b0;
  bit    last_done = 1'b0;
  string idle_tag = "R1";
  int    pub_hi = 0;
  int    pub_code = 0;

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, expv, $time);
    end
  endtask

  function automatic exp_t mk(int kind, int amp, bit dn, int row, int col, int rd, int tm, string tag);
    exp_t e;
    e.kind = kind; e.amp = amp; e.done = dn; e.row = row; e.col = col;
    e.rd = rd; e.tm = tm; e.tag = tag;
    return e;
  endfunction

  task automatic compare();
    exp_t e;
    bit   exp_busy;
    if (q.size() > 0) e = q.pop_front();
    else e = mk(0, 0, 1'b0, -1, -1, -1, -1, idle_tag);
    exp_busy = (e.kind != 0) || e.done;
    chk(int'(drv_kind) == e.kind, e.tag, "drv_kind", int'(drv_kind), e.kind);
    chk(int'(drv_amp) == e.amp, e.tag, "drv_amp", int'(drv_amp), e.amp);
    chk(done == e.done, e.tag, "done", int'(done), int'(e.done));
    chk(busy == exp_busy, e.tag, "busy", int'(busy), int'(exp_busy));
    if (e.row >= 0) begin
      chk(int'(drv_row) == e.row, "R11", "drv_row", int'(drv_row), e.row);
      chk(int'(drv_col) == e.col, "R11", "drv_col", int'(drv_col), e.col);
    end
    if (e.done && e.rd >= 0) exp_rdata = e.rd;
    if (e.kind == 0) chk(int'(rdata) == exp_rdata, "R3", "rdata", int'(rdata), exp_rdata);
    chk(tamper == exp_tamper, "R9/R10", "tamper", int'(tamper), int'(exp_tamper));
    if (e.done && e.tm == 1) exp_tamper = 1'b1;
    last_done = e.done;
    // true sense values only while the public pulse is on, decoys elsewhere
    if (e.kind == 1) begin
      sense_hi   = pub_hi[0];
      sense_code = pub_code[7:0];
    end else begin
      sense_hi   = ~pub_hi[0];
      sense_code = pub_code[7:0] ^ 8'h5A;
    end
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
  endtask

  task automatic wait_idle();
    while (q.size() > 0 || last_done) tick();
  endtask

  task automatic issue(int op, int row, int col, int wbit, int ex, int tol, int shi, int scode);
    int diff;
    cmd_valid  = 1'b1;
    cmd_op     = op[1:0];
    cmd_row    = row[3:0];
    cmd_col    = col[3:0];
    cmd_wbit   = wbit[0];
    cmd_expect = ex[7:0];
    cmd_tol    = tol[7:0];
    if (q.size() == 0 && !last_done) begin
      pub_hi   = shi;
      pub_code = scode;
      sense_hi   = ~pub_hi[0];
      sense_code = pub_code[7:0] ^ 8'h5A;
      if (op == 1) begin
        for (int i = 0; i < WR_DUR_T; i++)
          q.push_back(mk(wbit ? 3 : 4, wbit ? SET_AMP_T : RESET_AMP_T, 1'b0, row, col, -1, -1, "R4"));
        q.push_back(mk(0, 0, 1'b1, row, col, -1, -1, "R5"));
      end else if ((op == 0 || op == 2) && locked_m) begin
        diff = (scode >= ex) ? scode - ex : ex - scode;
        for (int i = 0; i < PUB_DUR_T; i++)
          q.push_back(mk(1, PUB_AMP_T, 1'b0, row, col, -1, -1, "R2"));
        for (int i = 0; i <= key_dur_m; i++)
          q.push_back(mk(2, key_amp_m, 1'b0, row, col, -1, -1, "R2/R6"));
        q.push_back(mk(0, 0, 1'b1, row, col, shi, (op == 2) ? int'(diff > tol) : -1, "R5"));
      end
    end
    tick();
    cmd_valid = 1'b0;
  endtask

  task automatic load_key(int a, int d);
    key_we  = 1'b1;
    key_amp = a[5:0];
    key_dur = d[3:0];
    if (!locked_m) begin
      locked_m  = 1'b1;
      key_amp_m = a;
      key_dur_m = d;
    end
    tick();
    key_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1: reset state
    idle_tag = "R1";
    repeat (3) tick();

    // R7: reads, verifies and op 3 dropped with no key stored
    idle_tag = "R7";
    issue(0, 2, 3, 0, 0, 0, 1, 10);
    tick();
    issue(2, 2, 3, 0, 50, 0, 1, 10);
    tick();
    issue(3, 2, 3, 0, 0, 0, 1, 10);
    repeat (3) tick();

    // R4: writes without a key, both polarities
    idle_tag = "R4";
    issue(1, 3, 5, 1, 0, 0, 0, 0);
    wait_idle();
    issue(1, 6, 1, 0, 0, 0, 0, 0);
    wait_idle();

    // R6: key is write-once
    load_key(21, 2);
    idle_tag = "R6";
    load_key(5, 0);
    tick();

    // R2, R3: protected reads with true and decoy sense values
    idle_tag = "R3";
    issue(0, 7, 9, 0, 0, 0, 1, 77);
    wait_idle();
    issue(0, 8, 10, 0, 0, 0, 0, 77);
    wait_idle();
    issue(0, 15, 15, 0, 0, 0, 1, 77);
    wait_idle();
    issue(1, 4, 4, 0, 0, 0, 0, 0);   // write keeps rdata
    wait_idle();

    // R8: commands and key writes while busy are dropped
    idle_tag = "R8";
    issue(0, 1, 2, 0, 0, 0, 0, 33);
    tick();
    issue(1, 9, 9, 1, 0, 0, 0, 0);
    load_key(9, 1);
    wait_idle();
    issue(0, 5, 6, 0, 0, 0, 1, 33);  // back-to-back after done
    wait_idle();

    // R9: tolerance compare on both sides, boundary included
    idle_tag = "R9";
    issue(2, 3, 3, 0, 105, 5, 1, 100);
    wait_idle();
    issue(2, 3, 4, 0, 100, 20, 0, 120);
    wait_idle();
    issue(2, 3, 5, 0, 106, 5, 1, 100);
    wait_idle();
    tick();

    // R10: flag stays through later clean verify and write
    idle_tag = "R10";
    issue(2, 2, 2, 0, 100, 0, 1, 100);
    wait_idle();
    issue(1, 2, 2, 1, 0, 0, 0, 0);
    wait_idle();
    repeat (3) tick();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R5 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule